// File: doc/BRIEF.md
# Triangular Spread-Spectrum Fraction Generator

This block sequences the fractional word fed to the sigma-delta modulator of a fractional-N feedback divider. The synthesized frequency then follows a triangular down-spread profile. While spread mode is off, the output follows the programmed nominal word. When spread mode is on, the word steps down from nominal by a fixed decrement, reaches a floor after a programmed number of steps, and climbs back to nominal. This repeats until spread mode is turned off. The word is never above nominal, so only down-spread exists.

The step rate comes from a prescaler that divides the reference clock by an integer. One triangle period spans twice the step count of updates. The modulation frequency is therefore the reference frequency divided by twice the product of the step count and the divider. The profile settings are captured only while spread mode is idle, so a running ramp cannot be disturbed. A one-cycle flag marks each turning point of the ramp.

Top module: `ssc_frac_gen`

## Requirements
- R1: With `spread_en_i` low at a rising edge, `frac_o` equals the `frac_nom_i` sampled at that edge and `extreme_o` is 0 after that edge.
- R2: With spread enabled, the word moves by one step per update. It goes down for `num_steps_i` updates, then up for `num_steps_i` updates, back to nominal. This repeats with a period of 2×`num_steps_i` updates.
- R3: The word never exceeds the captured nominal. Its lowest value is nominal minus step×`num_steps_i`, for example 3072 − 681×3 = 1029.
- R4: The n-th update takes effect at the n×D-th rising edge after the first edge that samples `spread_en_i` high, where D is the captured `clk_div_i`. `frac_o` does not change between updates.
- R5: A divider value of 0 behaves exactly like 1: one update on every edge.
- R6: A step count of 0 holds the word at nominal and never raises `extreme_o`.
- R7: `frac_nom_i`, `frac_step_i`, `num_steps_i` and `clk_div_i` are captured only at edges where `spread_en_i` is low. Changes made while spread is enabled have no effect on `frac_o`.
- R8: `extreme_o` is high for the single cycle in which `frac_o` first shows the floor value, or first shows nominal again after an up ramp. It is low otherwise.
- R9: If step×count exceeds the nominal, any word below zero is output as 0.
- R10: During reset, `frac_o` and `extreme_o` are 0. Turning spread off clears the ramp position, so re-enabling restarts the profile from nominal on its down ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_en_i | input | 1 | Spread mode enable |
| frac_nom_i | input | 12 | Nominal fractional word |
| frac_step_i | input | 12 | Decrement per update |
| num_steps_i | input | 8 | Updates per half period |
| clk_div_i | input | 8 | Reference divider for the update strobe (0 acts as 1) |
| frac_o | output | 12 | Fractional word to the modulator |
| extreme_o | output | 1 | One-cycle pulse at the floor and at the return to nominal |

## Verification
Every result is due at the first rising edge that samples the stimulus. An idle edge shows the new nominal. The n-th update of an enabled run shows at edge n×D, counted from the first enabled edge, with its turning-point pulse in that same cycle. The driver sets inputs on the falling edge and queues the value due at the next rising edge. The monitor compares one quarter period after that rising edge, so each queued item is paired with exactly one edge. During every enabled run the driver scrambles the profile inputs, so each enabled comparison also tests that capture holds only while idle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero divider acts as one
  assign lim      = (div_i == '0) ? '0 : div_i - 1'b1;
  assign strobe_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
  import ssc_pkg::*;
#(
  parameter int unsigned STEP_W = 12,
  parameter int unsigned NSTEP_W = 8,
  localparam int unsigned DEV_W = STEP_W + NSTEP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               strobe_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [NSTEP_W-1:0] nsteps_i,
  output logic [DEV_W-1:0]   dev_o,
  output logic               ext_o
);
  logic [NSTEP_W-1:0] cnt_q;
  ramp_dir_e          dir_q;
  logic [DEV_W-1:0]   dev_q;
  logic               ext_q;
  logic [DEV_W-1:0]   step_ext;
  logic               last_step;

  assign step_ext  = DEV_W'(step_i);
  assign last_step = (cnt_q == nsteps_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
      dev_q <= '0;
      ext_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
      dev_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= 1'b0;
      if (strobe_i && (nsteps_i != '0)) begin
        dev_q <= (dir_q == DIR_DOWN) ? dev_q + step_ext : dev_q - step_ext;
        if (last_step) begin
          cnt_q <= '0;
          dir_q <= (dir_q == DIR_DOWN) ? DIR_UP : DIR_DOWN;
          ext_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dev_o = dev_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/ssc_word_map.sv
module ssc_word_map #(
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned DEV_W = 20
) (
  input  logic [FRAC_W-1:0] nom_i,
  input  logic [DEV_W-1:0]  dev_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int unsigned W = (FRAC_W > DEV_W) ? FRAC_W : DEV_W;
  logic [W-1:0] nom_x;
  logic [W-1:0] dev_x;
  logic [W-1:0] diff;

  assign nom_x = W'(nom_i);
  assign dev_x = W'(dev_i);
  assign diff  = nom_x - dev_x;
  // floor at zero
  assign frac_o = (dev_x > nom_x) ? '0 : diff[FRAC_W-1:0];
endmodule

// File: rtl/ssc_frac_gen.sv
module ssc_frac_gen #(
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned STEP_W = 12,
  parameter int unsigned NSTEP_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               spread_en_i,
  input  logic [FRAC_W-1:0]  frac_nom_i,
  input  logic [STEP_W-1:0]  frac_step_i,
  input  logic [NSTEP_W-1:0] num_steps_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  output logic [FRAC_W-1:0]  frac_o,
  output logic               extreme_o
);
  localparam int unsigned DEV_W = STEP_W + NSTEP_W;

  logic [FRAC_W-1:0]  nom_q;
  logic [STEP_W-1:0]  step_q;
  logic [NSTEP_W-1:0] nsteps_q;
  logic [DIV_W-1:0]   div_q;
  logic               strobe;
  logic [DEV_W-1:0]   dev;

  // profile captured only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_q    <= '0;
      step_q   <= '0;
      nsteps_q <= '0;
      div_q    <= '0;
    end else if (!spread_en_i) begin
      nom_q    <= frac_nom_i;
      step_q   <= frac_step_i;
      nsteps_q <= num_steps_i;
      div_q    <= clk_div_i;
    end
  end

  ssc_prescaler #(.DIV_W(DIV_W)) i_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (spread_en_i),
    .div_i    (div_q),
    .strobe_o (strobe)
  );

  ssc_ramp #(.STEP_W(STEP_W), .NSTEP_W(NSTEP_W)) i_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (spread_en_i),
    .strobe_i (strobe),
    .step_i   (step_q),
    .nsteps_i (nsteps_q),
    .dev_o    (dev),
    .ext_o    (extreme_o)
  );

  ssc_word_map #(.FRAC_W(FRAC_W), .DEV_W(DEV_W)) i_word_map (
    .nom_i  (nom_q),
    .dev_i  (dev),
    .frac_o (frac_o)
  );
endmodule

// File: rtl/ssc_frac_gen_chk.sv
module ssc_frac_gen_chk #(
  parameter int unsigned FRAC_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spread_en_i,
  input logic [FRAC_W-1:0] frac_nom_i,
  input logic [FRAC_W-1:0] frac_o,
  input logic              extreme_o,
  input logic [FRAC_W-1:0] nom_q,
  input logic              strobe
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(spread_en_i)) |-> (frac_o == $past(frac_nom_i) && !extreme_o));

  // R3
  below_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_o <= nom_q);

  // R7
  profile_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(spread_en_i)) |-> $stable(nom_q));

  // R4
  no_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(spread_en_i) && !$past(strobe)) |-> $stable(frac_o));

  // R8
  pulse_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && extreme_o) |-> ($past(strobe) && $past(spread_en_i)));
endmodule

bind ssc_frac_gen ssc_frac_gen_chk #(.FRAC_W(FRAC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .spread_en_i (spread_en_i),
  .frac_nom_i  (frac_nom_i),
  .frac_o      (frac_o),
  .extreme_o   (extreme_o),
  .nom_q       (nom_q),
  .strobe      (strobe)
);

// File: tb/test_ssc_frac_gen.sv
module test_ssc_frac_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    frac;
    bit    ext;
    string req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        spread_en_i = 1'b0;
  logic [11:0] frac_nom_i = '0;
  logic [11:0] frac_step_i = '0;
  logic [7:0]  num_steps_i = '0;
  logic [7:0]  clk_div_i = '0;
  logic [11:0] frac_o;
  logic        extreme_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ssc_frac_gen i_ssc_frac_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .spread_en_i (spread_en_i),
    .frac_nom_i  (frac_nom_i),
    .frac_step_i (frac_step_i),
    .num_steps_i (num_steps_i),
    .clk_div_i   (clk_div_i),
    .frac_o      (frac_o),
    .extreme_o   (extreme_o)
  );

  task automatic check(input string req, input int act_f, input int exp_f,
                       input bit act_e, input bit exp_e);
    checks++;
    if (act_f != exp_f || act_e != exp_e) begin
      errors++;
      $display("FAIL %s: frac=%0d ext=%0b expected frac=%0d ext=%0b",
               req, act_f, act_e, exp_f, exp_e);
    end
  endtask

  // monitor: one queued item per rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.req, int'(frac_o), it.frac, extreme_o, it.ext);
      end
    end
  end

  // driver: idle phase then enabled phase with scrambled profile inputs (R7)
  task automatic run(input int nom, input int step, input int n, input int div,
                     input int idle_cyc, input int en_cyc, input string req);
    int d;
    d = (div == 0) ? 1 : div;
    for (int i = 0; i < idle_cyc; i++) begin
      @(negedge clk_i);
      spread_en_i = 1'b0;
      frac_nom_i  = 12'(nom);
      frac_step_i = 12'(step);
      num_steps_i = 8'(n);
      clk_div_i   = 8'(div);
      exp_q.push_back('{nom, 1'b0, "R1"});
    end
    for (int k = 1; k <= en_cyc; k++) begin
      int s, p, idx, dv, f;
      bit e;
      @(negedge clk_i);
      spread_en_i = 1'b1;
      frac_nom_i  = 12'($urandom);
      frac_step_i = 12'($urandom);
      num_steps_i = 8'($urandom);
      clk_div_i   = 8'($urandom);
      s = k / d;
      if (n == 0) begin
        f = nom;
        e = 1'b0;
      end else begin
        p   = s % (2 * n);
        idx = (p <= n) ? p : 2 * n - p;
        dv  = idx * step;
        f   = (dv > nom) ? 0 : nom - dv;
        e   = (s > 0) && (k % d == 0) && (p == n || p == 0);
      end
      exp_q.push_back('{f, e, req});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    #(CLK_PERIOD * 3);
    check("R10", int'(frac_o), 0, extreme_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    run(3072, 3, 8, 4, 3, 160, "R2");
    run(3072, 681, 3, 1, 2, 20, "R3");
    run(2000, 7, 4, 5, 2, 90, "R4");
    run(1500, 5, 4, 0, 2, 30, "R5");
    run(900, 9, 0, 2, 2, 20, "R6");
    run(3000, 50, 6, 2, 2, 17, "R7");
    run(10, 4, 4, 1, 2, 20, "R9");
    run(500, 20, 1, 3, 2, 24, "R8");
    // disable mid-ramp, re-enable: restart from nominal
    run(2500, 11, 5, 2, 1, 7, "R10");
    run(2500, 11, 5, 2, 1, 30, "R10");
    run(2500, 11, 5, 2, 3, 0, "R1");

    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule